// File: doc/BRIEF.md
# VPW Pulse-Width Symbol Receiver

This block watches one single-wire bus line whose symbols are coded by pulse duration, and turns the time between line transitions into symbol strobes. A one-per-microsecond clock-enable (`us_tick`) paces a saturating interval timer. At every transition of the synchronised line, the length of the pulse that just ended is classified against a set of duration windows. While hunting for a frame, only a start-of-frame pulse at the active level is accepted. Its length also tells the receiver whether the frame runs at normal rate or at four times that rate. From then on, every duration window is divided by the rate factor.

In the data phase, each pulse yields one bit. The value depends on both the pulse duration and the line level during the pulse. A line that stays quiet for the gap time closes the frame. Very short blips are dropped. Any other pulse that cannot be classified raises an error and sends the receiver back to hunting for the next start of frame. Assembling bytes and parsing frames belong to the logic downstream.

Top module: `vpw_symbol_rx`

## Requirements
- R1: In the hunt phase, an active-level pulse of 164 to 244 ticks gives one `sof_strobe` with `rate_fast`=0. An active-level pulse of 41 to 60 ticks gives one with `rate_fast`=1 (4x rate). Durations are counted in `us_tick` pulses, not in clock cycles.
- R2: In the hunt phase, no strobe comes from any other pulse. This includes pulses at the passive level and active pulses of 163, 245, 40 or 61 ticks.
- R3: In the data phase, a pulse is short if it lasts 24 to 96 ticks and long if it lasts 97 to 169 ticks. At 4x rate these windows become 6 to 23 and 24 to 41 ticks. Each short or long pulse gives exactly one `bit_valid` strobe.
- R4: A short pulse gives `bit_value`=1 at the active level and 0 at the passive level.
- R5: A long pulse gives `bit_value`=0 at the active level and 1 at the passive level.
- R6: In the data phase, once 240 ticks have passed without a transition (60 at 4x rate), `eof_strobe` pulses at that moment, without waiting for a later transition. The receiver then returns to the hunt phase. This also holds when a transition lands on the very tick that completes the gap.
- R7: In the data phase, a pulse of 2 ticks or fewer is ignored. It gives no strobe and leaves the phase unchanged. A 3-tick pulse at normal rate is an error.
- R8: In the data phase, any other pulse gives one `err_strobe`. The receiver then hunts again and gives no bit until a new start of frame, which is decoded normally.
- R9: `act_level` selects the active line level: 0 means low is active, 1 means high is active.
- R10: The interval timer saturates and does not wrap. An active pulse of 712 ticks in the hunt phase is not taken as a start of frame.
- R11: `bit_valid`, `sof_strobe`, `eof_strobe` and `err_strobe` are one-cycle pulses, and at most one of them is high in any cycle.
- R12: `rate_fast` changes only in the cycle in which `sof_strobe` is high.
- R13: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| us_tick | input | 1 | Clock enable, one pulse per microsecond |
| line_in | input | 1 | Asynchronous bus line |
| act_level | input | 1 | Active line level (0 = low active) |
| bit_valid | output | 1 | One-cycle strobe: a data bit was decoded |
| bit_value | output | 1 | Decoded bit, valid with `bit_valid` |
| sof_strobe | output | 1 | One-cycle strobe: start of frame accepted |
| rate_fast | output | 1 | Rate of the last start of frame (1 = 4x) |
| eof_strobe | output | 1 | One-cycle strobe: end-of-frame gap expired |
| err_strobe | output | 1 | One-cycle strobe: unclassifiable pulse in a frame |

## Verification
The gap timeout and the classification of a transition can fall in the same cycle. This happens when a data-phase pulse lasts exactly the gap length: 240 ticks at normal rate or 60 at 4x rate. The bench provokes this by placing a transition on that exact tick. It judges the result correct only if the frame closes with an end-of-frame strobe and no error or bit, while a pulse one tick shorter must give an error. The saturating timer and the timeout also meet when a long quiet line follows a frame. For that case the bench times when the end-of-frame strobe appears, relative to the last transition.

// File: rtl/vpw_rx_pkg.sv
// Shared types for the pulse-width symbol receiver.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package vpw_rx_pkg;

    // Classification of a data-phase pulse duration.
    typedef enum logic [1:0] {
        SYM_BAD    = 2'd0,
        SYM_GLITCH = 2'd1,
        SYM_SHORT  = 2'd2,
        SYM_LONG   = 2'd3
    } sym_e;

    // Receiver phase: hunting for a start of frame, or inside a frame.
    typedef enum logic {
        PH_HUNT = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/vpw_line_sync.sv
// Brings the asynchronous bus line into the clock domain through a chain
// of STAGES flops. It keeps one more flop of history so that transitions
// can be detected on the synchronised signal.
// Assumes STAGES >= 2. The held level is the level of the pulse that
// ends when edge_seen is high.
module vpw_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic lvl_held,
    output logic edge_seen
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    // Shift the raw line through the synchroniser and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {DEPTH{RST_LEVEL}};
        else        chain_q <= {chain_q[DEPTH-2:0], line_in};
    end

    assign lvl_held  = chain_q[STAGES];
    assign edge_seen = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/vpw_span_timer.sv
// Counts us_tick pulses since the last line transition. The count
// saturates at all-ones, so long quiet periods cannot alias. span is the
// duration including the current cycle's tick. restart clears the
// count after the current cycle.
// Assumes the saturation value exceeds every window limit in use.
module vpw_span_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] span
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt_q;

    // Duration seen so far, including this cycle's tick, saturating.
    always_comb begin
        span = (tick && (cnt_q != SAT)) ? cnt_q + 1'b1 : cnt_q;
    end

    // Hold the running duration; start over after a transition.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= SAT;
        else if (restart) cnt_q <= '0;
        else              cnt_q <= span;
    end
endmodule

// File: rtl/vpw_window_classify.sv
// Compares a pulse duration against the duration windows for both rates
// at once. One copy of the comparators per rate is generated. Start of
// frame is reported for both rates; data symbols and the gap timeout are
// taken from the rate selected by `fast`.
// Assumes SHORT_MIN > GLITCH_MAX and that windows scaled by FAST_DIV
// stay non-empty.
module vpw_window_classify
    import vpw_rx_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int SOF_MIN    = 164,
    parameter int SOF_LIM    = 245,
    parameter int SHORT_MIN  = 24,
    parameter int SPLIT      = 97,
    parameter int LONG_LIM   = 170,
    parameter int GAP_LEN    = 240,
    parameter int GLITCH_MAX = 2,
    parameter int FAST_DIV   = 4
) (
    input  logic [CNT_W-1:0] span,
    input  logic             fast,
    output logic             sof_norm,
    output logic             sof_quick,
    output sym_e             sym,
    output logic             gap_done
);
    localparam int                NRATES = 2;
    localparam logic [CNT_W-1:0] GL_MAX = CNT_W'(GLITCH_MAX);

    logic [NRATES-1:0] sof_hit;
    logic [NRATES-1:0] short_hit;
    logic [NRATES-1:0] long_hit;
    logic [NRATES-1:0] gap_hit;

    for (genvar r = 0; r < NRATES; r++) begin : g_rate
        localparam int               DIV    = (r == 0) ? 1 : FAST_DIV;
        localparam logic [CNT_W-1:0] SOF_LO = CNT_W'(SOF_MIN / DIV);
        localparam logic [CNT_W-1:0] SOF_HI = CNT_W'(SOF_LIM / DIV);
        localparam logic [CNT_W-1:0] SH_LO  = CNT_W'(SHORT_MIN / DIV);
        localparam logic [CNT_W-1:0] MID    = CNT_W'(SPLIT / DIV);
        localparam logic [CNT_W-1:0] LG_HI  = CNT_W'(LONG_LIM / DIV);
        localparam logic [CNT_W-1:0] GAP    = CNT_W'(GAP_LEN / DIV);

        // Window membership for this rate.
        always_comb begin
            sof_hit[r]   = (span >= SOF_LO) && (span < SOF_HI);
            short_hit[r] = (span >= SH_LO)  && (span < MID);
            long_hit[r]  = (span >= MID)    && (span < LG_HI);
            gap_hit[r]   = (span >= GAP);
        end
    end

    // Pick the data-phase class for the selected rate.
    always_comb begin
        sof_norm  = sof_hit[0];
        sof_quick = sof_hit[1];
        gap_done  = gap_hit[fast];
        if (short_hit[fast])     sym = SYM_SHORT;
        else if (long_hit[fast]) sym = SYM_LONG;
        else if (span <= GL_MAX) sym = SYM_GLITCH;
        else                     sym = SYM_BAD;
    end
endmodule

// File: rtl/vpw_symbol_rx.sv
// Pulse-width symbol receiver top. It synchronises the line, times each
// pulse in microsecond ticks, classifies it, and runs the hunt/data
// phase control. All outputs are registered one-cycle strobes, except
// rate_fast, which holds the rate of the last accepted start of frame.
// Assumes act_level is static while frames are in flight. Latency from
// a line transition to its strobe is STAGES + 1 cycles.
module vpw_symbol_rx
    import vpw_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 9,
    parameter int SOF_MIN     = 164,
    parameter int SOF_LIM     = 245,
    parameter int SHORT_MIN   = 24,
    parameter int SPLIT       = 97,
    parameter int LONG_LIM    = 170,
    parameter int GAP_LEN     = 240,
    parameter int GLITCH_MAX  = 2,
    parameter int FAST_DIV    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic line_in,
    input  logic act_level,
    output logic bit_valid,
    output logic bit_value,
    output logic sof_strobe,
    output logic rate_fast,
    output logic eof_strobe,
    output logic err_strobe
);
    logic             lvl_held;
    logic             edge_seen;
    logic [CNT_W-1:0] span;
    logic             sof_norm;
    logic             sof_quick;
    sym_e             sym;
    logic             gap_done;
    logic             pulse_active;

    phase_e phase_q, phase_d;
    logic   fast_q, fast_d;
    logic   bv_d, bval_d, sof_d, eof_d, err_d;

    vpw_line_sync #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (1'b1)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .lvl_held  (lvl_held),
        .edge_seen (edge_seen)
    );

    vpw_span_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (us_tick),
        .restart (edge_seen),
        .span    (span)
    );

    vpw_window_classify #(
        .CNT_W      (CNT_W),
        .SOF_MIN    (SOF_MIN),
        .SOF_LIM    (SOF_LIM),
        .SHORT_MIN  (SHORT_MIN),
        .SPLIT      (SPLIT),
        .LONG_LIM   (LONG_LIM),
        .GAP_LEN    (GAP_LEN),
        .GLITCH_MAX (GLITCH_MAX),
        .FAST_DIV   (FAST_DIV)
    ) u_class (
        .span      (span),
        .fast      (fast_q),
        .sof_norm  (sof_norm),
        .sof_quick (sof_quick),
        .sym       (sym),
        .gap_done  (gap_done)
    );

    assign pulse_active = (lvl_held == act_level);

    // Phase control: accept a start of frame, decode bits, close on gap.
    always_comb begin
        phase_d = phase_q;
        fast_d  = fast_q;
        bv_d    = 1'b0;
        bval_d  = 1'b0;
        sof_d   = 1'b0;
        eof_d   = 1'b0;
        err_d   = 1'b0;
        unique case (phase_q)
            PH_HUNT: begin
                if (edge_seen && pulse_active && (sof_norm || sof_quick)) begin
                    sof_d   = 1'b1;
                    fast_d  = sof_quick && !sof_norm;
                    phase_d = PH_DATA;
                end
            end
            PH_DATA: begin
                if (gap_done) begin
                    eof_d   = 1'b1;
                    phase_d = PH_HUNT;
                end else if (edge_seen) begin
                    unique case (sym)
                        SYM_SHORT: begin
                            bv_d   = 1'b1;
                            bval_d = pulse_active;
                        end
                        SYM_LONG: begin
                            bv_d   = 1'b1;
                            bval_d = !pulse_active;
                        end
                        SYM_GLITCH: begin
                            bv_d = 1'b0;
                        end
                        default: begin
                            err_d   = 1'b1;
                            phase_d = PH_HUNT;
                        end
                    endcase
                end
            end
            default: phase_d = PH_HUNT;
        endcase
    end

    // Register phase, rate and the output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_HUNT;
            fast_q     <= 1'b0;
            bit_valid  <= 1'b0;
            bit_value  <= 1'b0;
            sof_strobe <= 1'b0;
            eof_strobe <= 1'b0;
            err_strobe <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            fast_q     <= fast_d;
            bit_valid  <= bv_d;
            bit_value  <= bval_d;
            sof_strobe <= sof_d;
            eof_strobe <= eof_d;
            err_strobe <= err_d;
        end
    end

    assign rate_fast = fast_q;
endmodule

// File: rtl/vpw_symbol_rx_chk.sv
// Property checker for the receiver's output strobes. It tracks frame
// state from the strobes alone and is bound to every instance of the top.
module vpw_symbol_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_valid,
    input logic sof_strobe,
    input logic rate_fast,
    input logic eof_strobe,
    input logic err_strobe
);
    logic framing_q;

    // Frame open from a start strobe until an end or error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                        framing_q <= 1'b0;
        else if (sof_strobe)               framing_q <= 1'b1;
        else if (eof_strobe || err_strobe) framing_q <= 1'b0;
    end

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_valid, sof_strobe, eof_strobe, err_strobe}));

    assert_eof_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eof_strobe |=> !eof_strobe);

    assert_sof_from_hunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sof_strobe |-> !framing_q);

    assert_bit_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> framing_q);

    assert_eof_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eof_strobe |-> framing_q);

    assert_err_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> framing_q);

    assert_rate_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_strobe |-> $stable(rate_fast));
endmodule

bind vpw_symbol_rx vpw_symbol_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .sof_strobe (sof_strobe),
    .rate_fast  (rate_fast),
    .eof_strobe (eof_strobe),
    .err_strobe (err_strobe)
);

// File: tb/vpw_symbol_rx_bench.sv
// Self-checking bench: a table of frames walked by one loop, then
// directed tests for window boundaries, glitches, errors and reset.
module vpw_symbol_rx_bench;
    logic clk       = 1'b0;
    logic rst_n     = 1'b0;
    logic us_tick   = 1'b1;
    logic line_in   = 1'b1;
    logic act_level = 1'b0;
    logic bit_valid, bit_value, sof_strobe, rate_fast, eof_strobe, err_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    int tick_ph  = 0;
    bit done     = 1'b0;

    int          n_bits, n_sof, n_eof, n_err;
    int          n_multi     = 0;
    int          n_rate_jump = 0;
    logic [31:0] bit_log;
    logic        fast_seen;
    logic        rate_prev = 1'b0;

    localparam int KIND_ZERO = 0;
    localparam int KIND_ONE  = 1;
    localparam int KIND_ERR  = 2;
    localparam int KIND_EOF  = 3;

    // {rate_fast, bit count, data}
    localparam int NVEC = 8;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 5'd8,  16'h00A5},
        {1'b0, 5'd8,  16'h0000},
        {1'b0, 5'd8,  16'h00FF},
        {1'b1, 5'd8,  16'h003C},
        {1'b1, 5'd16, 16'h1234},
        {1'b0, 5'd16, 16'hC0DE},
        {1'b1, 5'd1,  16'h0001},
        {1'b0, 5'd12, 16'h09F6}
    };

    vpw_symbol_rx u_vpw_symbol_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .line_in    (line_in),
        .act_level  (act_level),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value),
        .sof_strobe (sof_strobe),
        .rate_fast  (rate_fast),
        .eof_strobe (eof_strobe),
        .err_strobe (err_strobe)
    );

    always #5 clk = ~clk;

    // Microsecond enable, one per tick_div cycles.
    always @(posedge clk) begin
        #1;
        tick_ph = (tick_ph + 1) % tick_div;
        us_tick = (tick_ph == 0);
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((int'(bit_valid) + int'(sof_strobe) + int'(eof_strobe) + int'(err_strobe)) > 1)
                n_multi++;
            if ((rate_fast != rate_prev) && !sof_strobe) n_rate_jump++;
            rate_prev = rate_fast;
            if (bit_valid) begin
                n_bits++;
                bit_log = {bit_log[30:0], bit_value};
            end
            if (sof_strobe) begin
                n_sof++;
                fast_seen = rate_fast;
            end
            if (eof_strobe) n_eof++;
            if (err_strobe) n_err++;
        end
    end

    task automatic chk(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic clear_mon();
        n_bits    = 0;
        n_sof     = 0;
        n_eof     = 0;
        n_err     = 0;
        bit_log   = '0;
        fast_seen = 1'b0;
    endtask

    task automatic hold(input logic lvl, input int n);
        line_in = lvl;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input bit fast, input int nb, input logic [31:0] data);
        logic lvl;
        bit   b;
        bit   is_short;
        hold(!act_level, 40);
        hold(act_level, fast ? 50 : 200);
        lvl = !act_level;
        for (int i = nb - 1; i >= 0; i--) begin
            b        = data[i];
            is_short = (lvl == act_level) ? b : !b;
            hold(lvl, is_short ? (fast ? 16 : 64) : (fast ? 32 : 128));
            lvl = !lvl;
        end
        hold(lvl, 300);
        hold(!act_level, 20);
    endtask

    task automatic check_frame(input string what, input bit fast, input int nb, input logic [31:0] data);
        logic [31:0] mask;
        mask = (nb >= 32) ? '1 : ((32'd1 << nb) - 1);
        chk({"R1 sof count ", what}, n_sof, 1);
        chk({"R1 rate ", what}, int'(fast_seen), int'(fast));
        chk({"R3 bit count ", what}, n_bits, nb);
        chk({"R4 R5 bit values ", what}, int'(bit_log & mask), int'(data & mask));
        chk({"R6 eof count ", what}, n_eof, 1);
        chk({"R8 no error ", what}, n_err, 0);
    endtask

    task automatic sof_probe(input int len, input int expect_sof);
        clear_mon();
        hold(!act_level, 30);
        hold(act_level, len);
        hold(!act_level, 300);
        chk($sformatf("R1 R2 sof window len=%0d", len), n_sof, expect_sof);
        chk($sformatf("R6 eof after sof len=%0d", len), n_eof, expect_sof);
    endtask

    task automatic data_probe(input bit fast, input int len, input int kind, input string tag);
        clear_mon();
        hold(!act_level, 30);
        hold(act_level, fast ? 50 : 200);
        hold(!act_level, len);
        hold(act_level, 300);
        hold(!act_level, 20);
        case (kind)
            KIND_ZERO, KIND_ONE: begin
                chk($sformatf("%s bits len=%0d", tag, len), n_bits, 1);
                chk($sformatf("%s value len=%0d", tag, len), int'(bit_log[0]), kind);
                chk($sformatf("%s err len=%0d", tag, len), n_err, 0);
                chk($sformatf("%s eof len=%0d", tag, len), n_eof, 1);
            end
            KIND_ERR: begin
                chk($sformatf("%s bits len=%0d", tag, len), n_bits, 0);
                chk($sformatf("%s err len=%0d", tag, len), n_err, 1);
                chk($sformatf("%s eof len=%0d", tag, len), n_eof, 0);
            end
            default: begin
                chk($sformatf("%s bits len=%0d", tag, len), n_bits, 0);
                chk($sformatf("%s err len=%0d", tag, len), n_err, 0);
                chk($sformatf("%s eof len=%0d", tag, len), n_eof, 1);
            end
        endcase
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        clear_mon();
        // R13: outputs stay 0 during reset, even with a toggling line.
        repeat (2) @(posedge clk);
        #1 line_in = 1'b0;
        repeat (3) @(posedge clk);
        #1 line_in = 1'b1;
        @(negedge clk);
        chk("R13 outputs in reset",
            int'({bit_valid, bit_value, sof_strobe, rate_fast, eof_strobe, err_strobe}), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        hold(1'b1, 20);
        chk("R13 quiet after reset", n_sof + n_bits + n_eof + n_err, 0);

        // Table of frames.
        for (int v = 0; v < NVEC; v++) begin
            clear_mon();
            send_frame(VEC[v][21], int'(VEC[v][20:16]), {16'h0, VEC[v][15:0]});
            check_frame($sformatf("vec%0d", v), VEC[v][21], int'(VEC[v][20:16]), {16'h0, VEC[v][15:0]});
        end

        // R1 R2: start-of-frame windows at both rates.
        sof_probe(163, 0);
        sof_probe(164, 1);
        sof_probe(244, 1);
        sof_probe(245, 0);
        sof_probe(40, 0);
        sof_probe(41, 1);
        sof_probe(60, 1);
        sof_probe(61, 0);

        // R2: a passive pulse of start-of-frame length is ignored.
        clear_mon();
        hold(act_level, 100);
        hold(!act_level, 200);
        hold(act_level, 100);
        hold(!act_level, 300);
        chk("R2 passive sof-length pulse", n_sof + n_bits + n_eof + n_err, 0);

        // R10: a very long active pulse does not alias into the window.
        clear_mon();
        hold(!act_level, 30);
        hold(act_level, 712);
        hold(!act_level, 300);
        chk("R10 saturated interval not sof", n_sof, 0);

        // R3 R4 R5: short/long boundaries, passive level, both rates.
        data_probe(1'b0, 24,  KIND_ZERO, "R3 R4");
        data_probe(1'b0, 96,  KIND_ZERO, "R3 R4");
        data_probe(1'b0, 97,  KIND_ONE,  "R3 R5");
        data_probe(1'b0, 169, KIND_ONE,  "R3 R5");
        data_probe(1'b0, 23,  KIND_ERR,  "R3 R8");
        data_probe(1'b0, 170, KIND_ERR,  "R3 R8");
        data_probe(1'b1, 6,   KIND_ZERO, "R3 R4");
        data_probe(1'b1, 23,  KIND_ZERO, "R3 R4");
        data_probe(1'b1, 24,  KIND_ONE,  "R3 R5");
        data_probe(1'b1, 41,  KIND_ONE,  "R3 R5");
        data_probe(1'b1, 5,   KIND_ERR,  "R3 R8");
        data_probe(1'b1, 42,  KIND_ERR,  "R3 R8");

        // R6: transition on the timeout tick closes the frame, no error.
        data_probe(1'b0, 240, KIND_EOF, "R6 coincident");
        data_probe(1'b0, 239, KIND_ERR, "R6 R8 before gap");
        data_probe(1'b1, 60,  KIND_EOF, "R6 coincident fast");
        data_probe(1'b1, 59,  KIND_ERR, "R6 R8 before gap fast");

        // R7: glitches are dropped, a 3-tick pulse is an error.
        clear_mon();
        hold(!act_level, 30);
        hold(act_level, 200);
        hold(!act_level, 2);
        hold(act_level, 2);
        hold(!act_level, 64);
        hold(act_level, 300);
        hold(!act_level, 20);
        chk("R7 glitch bits", n_bits, 1);
        chk("R7 glitch value", int'(bit_log[0]), 0);
        chk("R7 glitch no error", n_err, 0);
        clear_mon();
        hold(!act_level, 30);
        hold(act_level, 50);
        hold(!act_level, 1);
        hold(act_level, 1);
        hold(!act_level, 16);
        hold(act_level, 300);
        hold(!act_level, 20);
        chk("R7 fast glitch bits", n_bits, 1);
        chk("R7 fast glitch no error", n_err, 0);
        data_probe(1'b0, 3, KIND_ERR, "R7 three ticks");

        // R8: after an error a new frame decodes normally.
        data_probe(1'b0, 10, KIND_ERR, "R8 bad pulse");
        clear_mon();
        send_frame(1'b0, 8, 32'h96);
        check_frame("R8 resync", 1'b0, 8, 32'h96);

        // R6: end of frame appears at the timeout, not at a later edge.
        clear_mon();
        hold(!act_level, 30);
        hold(act_level, 200);
        hold(!act_level, 64);
        hold(act_level, 236);
        chk("R6 no eof before timeout", n_eof, 0);
        chk("R6 bit before timeout", n_bits, 1);
        hold(act_level, 12);
        chk("R6 eof at timeout without edge", n_eof, 1);
        hold(!act_level, 20);

        // R1: durations count ticks, not cycles.
        tick_div = 2;
        hold(!act_level, 10);
        clear_mon();
        hold(!act_level, 60);
        hold(act_level, 400);
        hold(!act_level, 128);
        hold(act_level, 256);
        hold(!act_level, 256);
        hold(act_level, 600);
        hold(!act_level, 40);
        chk("R1 tick-paced sof", n_sof, 1);
        chk("R1 tick-paced bits", n_bits, 3);
        chk("R1 tick-paced values", int'(bit_log[2:0]), 1);
        chk("R1 tick-paced eof", n_eof, 1);
        tick_div = 1;
        hold(!act_level, 10);

        // R9: high-active polarity.
        hold(1'b1, 400);
        act_level = 1'b1;
        hold(1'b0, 50);
        clear_mon();
        send_frame(1'b0, 8, 32'h5A);
        check_frame("R9 high active", 1'b0, 8, 32'h5A);
        clear_mon();
        hold(1'b1, 30);
        hold(1'b0, 200);
        hold(1'b1, 300);
        chk("R9 low pulse not sof when high active", n_sof, 0);
        hold(1'b0, 400);
        act_level = 1'b0;
        hold(1'b1, 50);

        // R11 R12: strobe exclusivity and rate stability over the run.
        chk("R11 strobes exclusive", n_multi, 0);
        chk("R12 rate changes only at sof", n_rate_jump, 0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule